// File: doc/BRIEF.md
# Post-Reset Codec Start-Up Write Sequencer

This block masters a write-only register bus once the chip leaves internal reset. It plays back a fixed start-up script that brings a two-group, sixteen-channel codec chip set into normal operation. The script programs the test registers, powers the channels, loads the calibration tone amplitude and puts every channel into initialization mode. It then starts the first calibration phase on the signal processor, waits a fixed number of millisecond ticks and switches the channels to loopback. Next it starts the second calibration phase and waits again. Last, it soft-resets both groups and writes the test registers back to normal.

A pulse on `start` launches the script. Each write is held on the bus until the target accepts it. The two waits count an external one-millisecond tick. After the last write the block waits for the next rising edge of the frame sync input, then drops `busy` and raises `done`. `done` stays high until the next launch.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `wr_en` are all 0.
- R2: A `start` pulse sampled while `busy` is 0 gives, one cycle later, `busy`=1, `done`=0 and `wr_en`=1 with the first entry of the script (address 0x1510, data 0x0004).
- R3: While `wr_en` is 1 and `wr_rdy` is 0 at a clock edge, `wr_en`, `wr_addr` and `wr_data` keep their values in the next cycle. A write counts as done at an edge where both are 1, and the next entry is presented in the following cycle.
- R4: The first setup phase is 37 writes in this order. Data 0x0004 goes to 0x1510, then 0x1550. Data 0x8000 goes to 0x1500..0x1507 ascending, then 0x1540..0x1547. Data 0xAA20 goes to 0x0580, then 0xF49D to 0x0581. Data 0x0080 goes to 0x1518..0x151F, then 0x1558..0x155F. Last, data 0x0700 goes to 0x0002.
- R5: After the 0x0700 write, `wr_en` stays 0 while `WAIT_MS` (default 70) ticks are counted. The next write is presented in the cycle after the edge that samples the last of those ticks.
- R6: After the first wait, 17 writes follow in order. Data 0x8001 goes to 0x1518..0x151F, then 0x1558..0x155F. Then data 0x0720 goes to 0x0002.
- R7: After a second wait of `WAIT_MS` ticks, 4 writes follow in order: 0x8000 to 0x1517, 0x8000 to 0x1557, 0x0004 to 0x1510 and 0x0004 to 0x1550.
- R8: After the final write, `done` rises and `busy` falls one cycle after the first edge at which `fsync` is sampled 1 having been sampled 0 at the edge before. A level of `fsync` that is already high does not end the sequence.
- R9: A `start` pulse while `busy` is 1, during writes, waits or the final sync wait, has no effect on the script, its order or its end.
- R10: `ms_tick` pulses that arrive outside the two waits do not count toward either wait.
- R11: `wr_en` is 0 whenever `busy` is 0, and `done` is never 1 while `busy` is 1.
- R12: A `start` pulse while `done` is 1 and `busy` is 0 clears `done` and runs the whole script again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, acted on only when idle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| fsync | input | 1 | Frame sync, synchronous to `clk` |
| wr_rdy | input | 1 | Target accepts the presented write |
| wr_en | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished and aligned to a frame |

## Verification
The bench runs the whole script under three accept patterns: always ready, pseudo-random ready and ready once in five cycles. It matches every accepted write against a list it builds itself. A design that advanced before acceptance, or that used the wrong group stride or range order, would show up as a wrong or missing entry. It counts the ticks that fall inside each wait, while ticks keep arriving during the long write bursts. A timer that was off by one, or that also counted ticks outside the waits, would end a wait early. It holds `fsync` high across the final write and pokes `start` during writes and during the sync wait. A level-sensitive sync would finish at once, and a start that was not ignored would restart the script and repeat writes.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int unsigned SCR_W = 16;

    typedef enum logic [3:0] {
        SEG_TEST  = 4'd0,
        SEG_PWR   = 4'd1,
        SEG_SINE  = 4'd2,
        SEG_INIT  = 4'd3,
        SEG_CAL1  = 4'd4,
        SEG_WAIT1 = 4'd5,
        SEG_LOOP  = 4'd6,
        SEG_CAL2  = 4'd7,
        SEG_WAIT2 = 4'd8,
        SEG_SRST  = 4'd9,
        SEG_TEST2 = 4'd10
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SYNC = 2'd2
    } st_e;

    // span: 0 = one entry per group, 1 = two entries, 2 = one entry per channel
    typedef struct packed {
        logic             is_wait;
        logic [SCR_W-1:0] base;
        logic [1:0]       span;
        logic             two_grp;
        logic             alt;
        logic [SCR_W-1:0] d0;
        logic [SCR_W-1:0] d1;
    } seg_info_t;

    function automatic seg_info_t seg_lookup(seg_e s);
        seg_info_t r;
        r = '{is_wait: 1'b0, base: '0, span: 2'd0, two_grp: 1'b0,
              alt: 1'b0, d0: '0, d1: '0};
        case (s)
            SEG_TEST, SEG_TEST2: begin
                r.base = 16'h1510; r.two_grp = 1'b1; r.d0 = 16'h0004;
            end
            SEG_PWR: begin
                r.base = 16'h1500; r.span = 2'd2; r.two_grp = 1'b1; r.d0 = 16'h8000;
            end
            SEG_SINE: begin
                r.base = 16'h0580; r.span = 2'd1; r.alt = 1'b1;
                r.d0 = 16'hAA20; r.d1 = 16'hF49D;
            end
            SEG_INIT: begin
                r.base = 16'h1518; r.span = 2'd2; r.two_grp = 1'b1; r.d0 = 16'h0080;
            end
            SEG_CAL1: begin
                r.base = 16'h0002; r.d0 = 16'h0700;
            end
            SEG_LOOP: begin
                r.base = 16'h1518; r.span = 2'd2; r.two_grp = 1'b1; r.d0 = 16'h8001;
            end
            SEG_CAL2: begin
                r.base = 16'h0002; r.d0 = 16'h0720;
            end
            SEG_SRST: begin
                r.base = 16'h1517; r.two_grp = 1'b1; r.d0 = 16'h8000;
            end
            default: r.is_wait = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbs_script.sv
module cbs_script
    import cbs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned CH_PER_GRP   = 8,
    parameter int unsigned GROUP_STRIDE = 'h40,
    parameter int unsigned ELEM_W       = 5
) (
    input  seg_e              seg,
    input  logic [ELEM_W-1:0] elem,
    output logic              is_wait,
    output logic              last,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int unsigned LG_CH = $clog2(CH_PER_GRP);

    seg_info_t   info;
    int unsigned lg;
    int unsigned per;
    int unsigned total;
    int unsigned grp;
    int unsigned idx;

    assign info = seg_lookup(seg);

    always_comb begin
        case (info.span)
            2'd0:    lg = 0;
            2'd1:    lg = 1;
            default: lg = LG_CH;
        endcase
        per   = 32'd1 << lg;
        total = info.two_grp ? (per << 1) : per;
        grp   = info.two_grp ? (32'(elem) >> lg) : 32'd0;
        idx   = 32'(elem) & (per - 1);
        is_wait = info.is_wait;
        last    = (32'(elem) == total - 1);
        addr    = ADDR_W'(32'(info.base) + grp * GROUP_STRIDE + idx);
        data    = (info.alt && elem[0]) ? DATA_W'(info.d1) : DATA_W'(info.d0);
    end

endmodule

// File: rtl/cbs_tick_timer.sv
module cbs_tick_timer #(
    parameter int unsigned WAIT_MS = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(WAIT_MS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == CNT_W'(WAIT_MS - 1)) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cbs_rise.sv
module cbs_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic sig_d, sig_q;

    always_comb begin
        sig_d = sig;
        rise  = sig & ~sig_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_d;
    end

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cbs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned CH_PER_GRP   = 8,
    parameter int unsigned GROUP_STRIDE = 'h40,
    parameter int unsigned WAIT_MS      = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ms_tick,
    input  logic              fsync,
    input  logic              wr_rdy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);

    localparam int unsigned ELEM_W = $clog2(2 * CH_PER_GRP + 1);

    typedef struct packed {
        st_e               state;
        seg_e              seg;
        logic [ELEM_W-1:0] elem;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic is_wait;
    logic last;
    logic in_run;
    logic expire;
    logic fs_rise;

    cbs_script #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CH_PER_GRP  (CH_PER_GRP),
        .GROUP_STRIDE(GROUP_STRIDE),
        .ELEM_W      (ELEM_W)
    ) u_script (
        .seg    (ctl_q.seg),
        .elem   (ctl_q.elem),
        .is_wait(is_wait),
        .last   (last),
        .addr   (wr_addr),
        .data   (wr_data)
    );

    assign in_run = (ctl_q.state == ST_RUN);

    // timer runs only while a wait segment is current
    cbs_tick_timer #(
        .WAIT_MS(WAIT_MS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!(in_run && is_wait)),
        .tick  (ms_tick),
        .expire(expire)
    );

    cbs_rise u_fs (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (fsync),
        .rise (fs_rise)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.seg   = SEG_TEST;
                    ctl_d.elem  = '0;
                    ctl_d.done  = 1'b0;
                end
            end
            ST_RUN: begin
                if (is_wait) begin
                    if (expire) begin
                        ctl_d.seg  = seg_e'(ctl_q.seg + 4'd1);
                        ctl_d.elem = '0;
                    end
                end else if (wr_rdy) begin
                    if (last) begin
                        ctl_d.elem = '0;
                        if (ctl_q.seg == SEG_TEST2) ctl_d.state = ST_SYNC;
                        else                        ctl_d.seg   = seg_e'(ctl_q.seg + 4'd1);
                    end else begin
                        ctl_d.elem = ctl_q.elem + 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (fs_rise) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, seg: SEG_TEST, elem: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_en = in_run && !is_wait;
    assign busy  = (ctl_q.state != ST_IDLE);
    assign done  = ctl_q.done;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned WAIT_MS = 70
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ms_tick,
    input logic              fsync,
    input logic              wr_rdy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done
);

    // ticks seen while busy with no write pending, cleared on write or idle
    logic [15:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!busy || wr_en)   gap_q <= '0;
        else if (ms_tick && gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!busy && !done && !wr_en);
        end
    end

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && wr_en && wr_addr == ADDR_W'(16'h1510)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_rdy) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    a_r5_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_en) && $past(busy)) |-> (gap_q == 16'(WAIT_MS)));

    a_r8_frame_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(fsync) && !$past(fsync, 2)));

    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && start) |=> (busy && !done));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind cfg_boot_seq cbs_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WAIT_MS(WAIT_MS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ms_tick(ms_tick),
    .fsync  (fsync),
    .wr_rdy (wr_rdy),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_cfg_boot_seq.sv
module sim_cfg_boot_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MS    = 70;
    localparam int EXP_N      = 58;
    localparam int TICK_DIV   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic        fsync = 1'b0;
    logic        wr_rdy = 1'b0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        busy;
    logic        done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_boot_seq u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ms_tick(ms_tick),
        .fsync  (fsync),
        .wr_rdy (wr_rdy),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .busy   (busy),
        .done   (done)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_a [EXP_N];
    logic [15:0] exp_d [EXP_N];
    logic [15:0] log_a [64];
    logic [15:0] log_d [64];
    int          gap   [64];
    int          log_n = 0;

    int          rdy_mode = 0;
    int          fs_auto = 0;
    logic        fs_level = 1'b0;
    int          run_id = 0;
    int          seen_id = 0;
    int          acc = 0;
    int          hold_bad = 0;
    logic        prev_pend = 1'b0;
    logic [15:0] prev_a = '0;
    logic [15:0] prev_d = '0;
    int          cyc = 0;
    logic [7:0]  lfsr = 8'hA5;

    // bus responder, tick and frame source, write monitor
    always @(negedge clk) begin
        if (run_id != seen_id) begin
            seen_id   = run_id;
            log_n     = 0;
            acc       = 0;
            hold_bad  = 0;
            prev_pend = 1'b0;
        end
        if (prev_pend && !(wr_en && wr_addr == prev_a && wr_data == prev_d))
            hold_bad++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0:       wr_rdy = 1'b1;
            1:       wr_rdy = lfsr[0] | lfsr[2];
            default: wr_rdy = ((cyc % 5) == 4);
        endcase
        ms_tick = ((cyc % TICK_DIV) == 0);
        fsync   = (fs_auto != 0) ? ((cyc % 37) == 0) : fs_level;
        if (busy && !wr_en && ms_tick) acc++;
        if (wr_en && wr_rdy) begin
            if (log_n < 64) begin
                log_a[log_n] = wr_addr;
                log_d[log_n] = wr_data;
                gap[log_n]   = acc;
            end
            acc = 0;
            log_n++;
        end
        prev_pend = wr_en && !wr_rdy;
        prev_a    = wr_addr;
        prev_d    = wr_data;
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic add_exp(inout int k, input logic [15:0] a, input logic [15:0] d);
        exp_a[k] = a;
        exp_d[k] = d;
        k++;
    endtask

    task automatic build_expected();
        int k = 0;
        add_exp(k, 16'h1510, 16'h0004);
        add_exp(k, 16'h1550, 16'h0004);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1500 + 16'(i), 16'h8000);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1540 + 16'(i), 16'h8000);
        add_exp(k, 16'h0580, 16'hAA20);
        add_exp(k, 16'h0581, 16'hF49D);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1518 + 16'(i), 16'h0080);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1558 + 16'(i), 16'h0080);
        add_exp(k, 16'h0002, 16'h0700);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1518 + 16'(i), 16'h8001);
        for (int i = 0; i < 8; i++) add_exp(k, 16'h1558 + 16'(i), 16'h8001);
        add_exp(k, 16'h0002, 16'h0720);
        add_exp(k, 16'h1517, 16'h8000);
        add_exp(k, 16'h1557, 16'h8000);
        add_exp(k, 16'h1510, 16'h0004);
        add_exp(k, 16'h1550, 16'h0004);
    endtask

    task automatic check_range(input int lo, input int hi, input string req);
        int bad = -1;
        for (int i = lo; i < hi; i++) begin
            if (bad < 0 && (i >= log_n || log_a[i] != exp_a[i] || log_d[i] != exp_d[i]))
                bad = i;
        end
        if (bad < 0) chk(1'b1, req, "script entries", 0, 0);
        else if (bad >= log_n) chk(1'b0, req, "missing entry index", log_n, bad);
        else chk(1'b0, req, $sformatf("entry %0d {addr,data}", bad),
                 {log_a[bad], log_d[bad]}, {exp_a[bad], exp_d[bad]});
    endtask

    task automatic check_log();
        int stray = 0;
        chk(log_n == EXP_N, "R4", "accepted write count", log_n, EXP_N);
        check_range(0, 37, "R4");
        check_range(37, 54, "R6");
        check_range(54, EXP_N, "R7");
        chk(gap[37] == WAIT_MS, "R5,R10", "ticks in first wait", gap[37], WAIT_MS);
        chk(gap[54] == WAIT_MS, "R7,R10", "ticks in second wait", gap[54], WAIT_MS);
        for (int i = 0; i < EXP_N && i < log_n; i++)
            if (i != 37 && i != 54 && gap[i] != 0) stray++;
        chk(stray == 0, "R4", "write bursts without pauses", stray, 0);
        chk(hold_bad == 0, "R3", "held requests kept stable", hold_bad, 0);
    endtask

    task automatic launch(input string req);
        run_id++;
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy && !done && wr_en && wr_addr == 16'h1510 && wr_data == 16'h0004, req,
            "launch {busy,done,en,addr,data}",
            {busy, done, wr_en, wr_addr, wr_data}, {3'b101, 16'h1510, 16'h0004});
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 20000 && log_n < n; i++) step();
    endtask

    // full run, ready always, frame sync high across the final write
    task automatic t_held_sync();
        rdy_mode = 0;
        fs_auto  = 0;
        fs_level = 1'b0;
        launch("R2");
        wait_writes(50);
        fs_level = 1'b1;
        wait_writes(EXP_N);
        step(); step(); step();
        chk(busy && !done, "R8", "level-high frame sync ignored {busy,done}",
            {busy, done}, 2'b10);
        chk(!wr_en, "R11", "no request in sync wait", wr_en, 0);
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        chk(busy && !wr_en && !done, "R9", "start in sync wait {busy,en,done}",
            {busy, wr_en, done}, 3'b100);
        fs_level = 1'b0;
        step(); step();
        chk(!done, "R8", "no done on falling sync", done, 0);
        fs_level = 1'b1;
        step();
        chk(!done && busy, "R8", "done not before edge sampled", {busy, done}, 2'b10);
        step();
        chk(done && !busy, "R8", "done after sync edge {busy,done}", {busy, done}, 2'b01);
        fs_level = 1'b0;
        check_log();
    endtask

    // restart from done, random ready, periodic frame pulses
    task automatic t_restart_random();
        rdy_mode = 1;
        fs_auto  = 1;
        launch("R12");
        for (int i = 0; i < 20000 && busy; i++) step();
        chk(done && !busy, "R8", "run ended on a frame pulse {busy,done}",
            {busy, done}, 2'b01);
        fs_auto = 0;
        check_log();
        step(); step();
        chk(!wr_en && !busy && done, "R11", "idle after run {en,busy,done}",
            {wr_en, busy, done}, 3'b001);
    endtask

    // slow ready, start poked throughout the writes and waits
    task automatic t_start_poke();
        int pokes = 0;
        rdy_mode = 2;
        fs_auto  = 0;
        fs_level = 1'b0;
        launch("R12");
        while (log_n < EXP_N - 2 && pokes < 400) begin
            repeat (6) step();
            start = 1'b1;
            step();
            start = 1'b0;
            pokes++;
        end
        wait_writes(EXP_N);
        step(); step();
        chk(busy && !done, "R9", "still waiting for frame after pokes", {busy, done}, 2'b10);
        fs_level = 1'b1;
        step(); step();
        fs_level = 1'b0;
        chk(done && !busy, "R8", "done after frame edge", {busy, done}, 2'b01);
        check_log();
        chk(log_n == EXP_N, "R9", "no extra writes from pokes", log_n, EXP_N);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        build_expected();
        repeat (3) step();
        chk(!busy && !done && !wr_en, "R1", "reset {busy,done,en}",
            {busy, done, wr_en}, 3'b000);
        rst_n = 1'b1;
        step();
        chk(!busy && !done && !wr_en, "R1", "idle after reset {busy,done,en}",
            {busy, done, wr_en}, 3'b000);
        t_held_sync();
        t_restart_random();
        t_start_poke();
        finish_sim();
    end

endmodule